// File: doc/BRIEF.md
# Load Request Issue Controller

This block sits between the load-execution step and one data-cache request port. It takes one load at a time, a load that has already been found to need memory rather than store-queue forwarding, and decides what to do with it. It sends uncacheable loads on only when they are at the head of the load queue and ready to commit. Any other uncacheable load goes back for a later retry, and no memory traffic is generated for it. A load that crosses a cache-line boundary is sent as two requests. The low part goes first and the high part follows. Both parts share one completion counter, and that counter pulses a completion when the last response comes back.

If the cache is blocked when a load arrives, or if it refuses one of the load's requests, the block records that load as one that must later be replayed. Only the oldest such load is kept. The record carries a "handled" flag that the pipeline sets once it has reacted. The record stays valid until the pipeline clears it.

A `tick` input marks the start of each core cycle. Requests issued since the last tick are counted against the configured number of cache ports. No load is accepted whose requests would exceed that number.

Top module: `load_issue_ctrl`

## Requirements
- R1: An uncacheable load whose index differs from `head_idx`, or whose `req_at_commit` is low, is rejected. In the cycle after acceptance, `resched_valid` pulses for one cycle with `resched_idx` equal to the load index. The load issues no memory request, uses no cache port and creates no completion record.
- R2: An uncacheable load that is at the head and at commit is handled exactly like a cacheable load.
- R3: A load that is not split issues a single request in the cycle after acceptance, with `mem_hi`=0, `mem_off`=0, `mem_addr` equal to the load address and `mem_size` equal to the load size.
- R4: A split load first issues its low request: `mem_hi`=0, the load address, size LINE_BYTES minus the address offset within the line, and `mem_off`=0. One cycle after the low request is accepted, it issues its high request: `mem_hi`=1, the next line-aligned address, the remaining bytes as size, and `mem_off` equal to the low size.
- R5: Acceptance of an issued load sets its completion count to 1 (unsplit) or 2 (split). Each `rsp_valid` for that index decrements the count. The response that brings the count to zero pulses `done_valid` with `done_idx` one cycle later. A response for an index whose count is zero is ignored.
- R6: If the high request is refused (`mem_ready` low while `mem_hi`=1), the load's count is decremented once and `retry` pulses in the next cycle. A single response then completes the load.
- R7: If the low or unsplit request is refused, the load's completion record is discarded, so later responses for that index do not complete it. `retry` pulses in the next cycle, and the load is offered to the blocked-load record.
- R8: A load accepted while `cache_blocked` is high issues no request and uses no port. It is offered to the blocked-load record.
- R9: An offered load is recorded when no load is recorded yet, or when its sequence number is strictly smaller (unsigned) than the recorded one. Recording a load clears `blk_handled`. A `blk_ack` pulse sets `blk_handled`, and it then stays set.
- R10: `blk_valid` stays high until a `blk_clear` pulse, which clears it in the next cycle unless a new load is recorded in that same cycle.
- R11: `ports_used` returns to 0 in a cycle where `tick` is high. It adds 1 for each unsplit load and 2 for each split load that is issued to the cache. Rejected and blocked loads add nothing.
- R12: `req_ready` is high only while no request is in progress and the port count in effect for this cycle (0 when `tick` is high), plus the ports the offered load needs (2 if `req_split`, else 1), does not exceed NUM_PORTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Start of a core cycle; restarts port counting |
| req_valid | input | 1 | Load offered |
| req_ready | output | 1 | Load can be accepted this cycle |
| req_idx | input | IDX_W | Load-queue index of the load |
| req_seq | input | SEQ_W | Sequence number (smaller is older) |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | log2(LINE_BYTES)+1 | Size in bytes |
| req_uncached | input | 1 | Load is uncacheable |
| req_at_commit | input | 1 | Load is ready to commit |
| req_split | input | 1 | Load crosses a line and needs two requests |
| head_idx | input | IDX_W | Index of the load-queue head |
| cache_blocked | input | 1 | Cache cannot take requests |
| mem_valid | output | 1 | Cache request present |
| mem_ready | input | 1 | Cache takes the request this cycle |
| mem_addr | output | ADDR_W | Request address |
| mem_size | output | log2(LINE_BYTES)+1 | Request size in bytes |
| mem_off | output | log2(LINE_BYTES)+1 | Byte offset of this part in the load's data |
| mem_hi | output | 1 | Request is the high part of a split load |
| mem_idx | output | IDX_W | Load index of the request |
| rsp_valid | input | 1 | Cache response |
| rsp_idx | input | IDX_W | Load index of the response |
| resched_valid | output | 1 | Uncacheable load rejected |
| resched_idx | output | IDX_W | Index of the rejected load |
| retry | output | 1 | A request was refused |
| done_valid | output | 1 | A load has all its data |
| done_idx | output | IDX_W | Index of the completed load |
| blk_clear | input | 1 | Drop the blocked-load record |
| blk_ack | input | 1 | Mark the blocked load as handled |
| blk_valid | output | 1 | A blocked load is recorded |
| blk_seq | output | SEQ_W | Sequence number of the recorded load |
| blk_handled | output | 1 | Recorded load has been handled |
| ports_used | output | log2(NUM_PORTS+3) | Ports used in this core cycle |

## Verification
All outputs except `req_ready` come from registers. A result caused by the input at one clock edge is therefore visible during the cycle after that edge. A rejection, a blocked-load record, the first cache request and the port count appear one cycle after acceptance. `retry` and the high request appear one cycle after the edge that sampled `mem_ready`. `done_valid` appears one cycle after the draining response. The bench drives inputs on falling edges and reads each result on the falling edge that follows the edge which produces it. `req_ready` is combinational, so it is read shortly after the inputs are driven, in the same cycle. A bench model of the per-index counts, the blocked record and the port count supplies every expected value.

// File: rtl/lic_pkg.sv
`timescale 1ns/1ps
package lic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } lic_state_t;

  typedef enum logic [1:0] {
    CL_RESCHED = 2'd0,
    CL_BLOCK   = 2'd1,
    CL_ISSUE   = 2'd2
  } lic_class_t;
endpackage

// File: rtl/lic_gate.sv
`timescale 1ns/1ps
module lic_gate
  import lic_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int NUM_PORTS = 2,
  parameter int PC_W      = 3
) (
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [IDX_W-1:0] head_idx,
  input  logic             req_uncached,
  input  logic             req_at_commit,
  input  logic             req_split,
  input  logic             cache_blocked,
  input  logic             tick,
  input  logic             idle,
  input  logic [PC_W-1:0]  ports_used,
  output logic             req_ready,
  output logic             accept,
  output lic_class_t       cls,
  output logic [PC_W-1:0]  need,
  output logic [PC_W-1:0]  port_base
);
  logic head_ok;
  logic fits;

  always_comb begin
    port_base = tick ? '0 : ports_used;
    need      = req_split ? PC_W'(2) : PC_W'(1);
    fits      = (int'(port_base) + int'(need)) <= NUM_PORTS;
    req_ready = idle && fits;
    accept    = req_valid && req_ready;
  end

  always_comb begin
    head_ok = (req_idx == head_idx) && req_at_commit;
    if (req_uncached && !head_ok) begin
      cls = CL_RESCHED;
    end else if (cache_blocked) begin
      cls = CL_BLOCK;
    end else begin
      cls = CL_ISSUE;
    end
  end
endmodule

// File: rtl/lic_issue.sv
`timescale 1ns/1ps
module lic_issue
  import lic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int SEQ_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int NUM_PORTS  = 2,
  parameter int PC_W       = 3,
  parameter int OFF_W      = 4,
  parameter int SZ_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  lic_class_t        cls,
  input  logic [PC_W-1:0]   need,
  input  logic [PC_W-1:0]   port_base,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [SEQ_W-1:0]  req_seq,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_split,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SZ_W-1:0]   mem_size,
  output logic [SZ_W-1:0]   mem_off,
  output logic              mem_hi,
  output logic [IDX_W-1:0]  mem_idx,
  output logic              resched_valid,
  output logic [IDX_W-1:0]  resched_idx,
  output logic              retry,
  output logic [PC_W-1:0]   ports_used,
  output logic              idle,
  output logic              set_valid,
  output logic [IDX_W-1:0]  set_idx,
  output logic [1:0]        set_cnt,
  output logic              lo_fail,
  output logic              hi_fail,
  output logic [IDX_W-1:0]  fail_idx,
  output logic              blk_ev,
  output logic [SEQ_W-1:0]  blk_ev_seq
);
  localparam int LINE_HI_W = ADDR_W - OFF_W;

  lic_state_t        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SZ_W-1:0]   size_q;
  logic [SZ_W-1:0]   lo_q;
  logic              split_q;
  logic [SZ_W-1:0]   lo_sz;
  logic [LINE_HI_W-1:0] next_line;
  logic              issue_acc;
  logic              block_acc;
  logic              resched_acc;

  // Classified acceptance events
  always_comb begin
    issue_acc   = accept && (cls == CL_ISSUE);
    block_acc   = accept && (cls == CL_BLOCK);
    resched_acc = accept && (cls == CL_RESCHED);
  end

  // Size of the low part: up to the end of the line for a split load
  always_comb begin
    if (req_split) begin
      lo_sz = SZ_W'(LINE_BYTES) - {1'b0, req_addr[OFF_W-1:0]};
    end else begin
      lo_sz = req_size;
    end
  end

  // Request fields, derived from the held load
  always_comb begin
    next_line = addr_q[ADDR_W-1:OFF_W] + LINE_HI_W'(1);
    idle      = (st_q == ST_IDLE);
    mem_valid = !idle;
    mem_hi    = (st_q == ST_HI);
    mem_idx   = idx_q;
    if (st_q == ST_HI) begin
      mem_addr = {next_line, {OFF_W{1'b0}}};
      mem_size = size_q - lo_q;
      mem_off  = lo_q;
    end else begin
      mem_addr = addr_q;
      mem_size = lo_q;
      mem_off  = '0;
    end
  end

  // Events towards the completion table and the blocked-load record
  always_comb begin
    set_valid  = issue_acc;
    set_idx    = req_idx;
    set_cnt    = req_split ? 2'd2 : 2'd1;
    lo_fail    = (st_q == ST_LO) && !mem_ready;
    hi_fail    = (st_q == ST_HI) && !mem_ready;
    fail_idx   = idx_q;
    blk_ev     = block_acc || lo_fail || hi_fail;
    blk_ev_seq = block_acc ? req_seq : seq_q;
  end

  // Issue sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      seq_q   <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      lo_q    <= '0;
      split_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (issue_acc) begin
            st_q    <= ST_LO;
            idx_q   <= req_idx;
            seq_q   <= req_seq;
            addr_q  <= req_addr;
            size_q  <= req_size;
            lo_q    <= lo_sz;
            split_q <= req_split;
          end
        end
        ST_LO: begin
          if (mem_ready && split_q) begin
            st_q <= ST_HI;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_HI: begin
          st_q <= ST_IDLE;
        end
        default: begin
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  // Registered side outputs and per-cycle port count
  always_ff @(posedge clk) begin
    if (rst) begin
      resched_valid <= 1'b0;
      resched_idx   <= '0;
      retry         <= 1'b0;
      ports_used    <= '0;
    end else begin
      resched_valid <= resched_acc;
      resched_idx   <= req_idx;
      retry         <= lo_fail || hi_fail;
      ports_used    <= port_base + (issue_acc ? need : '0);
    end
  end

  // R11
  ports_cap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(ports_used) <= NUM_PORTS);

  // R4
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HI) |-> $past(st_q == ST_LO && mem_ready));

  // R1
  resched_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    resched_valid |-> $past(st_q == ST_IDLE));

  // R6
  retry_src_chk: assert property (@(posedge clk) disable iff (rst)
    retry |-> $past(st_q != ST_IDLE && !mem_ready));
endmodule

// File: rtl/lic_track.sv
`timescale 1ns/1ps
module lic_track #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_valid,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [1:0]       set_cnt,
  input  logic             lo_fail,
  input  logic             hi_fail,
  input  logic [IDX_W-1:0] fail_idx,
  input  logic             rsp_valid,
  input  logic [IDX_W-1:0] rsp_idx,
  output logic             done_valid,
  output logic [IDX_W-1:0] done_idx
);
  localparam int NE = 1 << IDX_W;

  logic [1:0]    cnt_q [NE];
  logic [1:0]    cnt_d [NE];
  logic [NE-1:0] live;
  logic [NE-1:0] rsp_hit;
  logic [NE-1:0] fail_hit;
  logic [NE-1:0] set_hit;
  logic [NE-1:0] clr_hit;
  logic [NE-1:0] drain;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    assign live[e]     = (cnt_q[e] != 2'd0);
    assign rsp_hit[e]  = rsp_valid && (rsp_idx == IDX_W'(e)) && live[e];
    assign fail_hit[e] = hi_fail && (fail_idx == IDX_W'(e)) && live[e];
    assign set_hit[e]  = set_valid && (set_idx == IDX_W'(e));
    assign clr_hit[e]  = lo_fail && (fail_idx == IDX_W'(e));
    assign drain[e]    = rsp_hit[e] && !set_hit[e] && !clr_hit[e] &&
                         (cnt_d[e] == 2'd0);
  end

  // Next count for each entry: load, discard, or count down
  always_comb begin
    for (int e = 0; e < NE; e++) begin
      logic [1:0] dec;
      dec = {1'b0, rsp_hit[e]} + {1'b0, fail_hit[e]};
      if (set_hit[e]) begin
        cnt_d[e] = set_cnt;
      end else if (clr_hit[e]) begin
        cnt_d[e] = 2'd0;
      end else if (dec >= cnt_q[e]) begin
        cnt_d[e] = 2'd0;
      end else begin
        cnt_d[e] = cnt_q[e] - dec;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NE; e++) begin
        cnt_q[e] <= 2'd0;
      end
      done_valid <= 1'b0;
      done_idx   <= '0;
    end else begin
      for (int e = 0; e < NE; e++) begin
        cnt_q[e] <= cnt_d[e];
      end
      done_valid <= |drain;
      done_idx   <= rsp_idx;
    end
  end

  // R5
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> ($past(rsp_valid) && done_idx == $past(rsp_idx)));
endmodule

// File: rtl/lic_blocked.sv
`timescale 1ns/1ps
module lic_blocked #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  logic [SEQ_W-1:0] ev_seq,
  input  logic             clr,
  input  logic             ack,
  output logic             blk_valid,
  output logic [SEQ_W-1:0] blk_seq,
  output logic             blk_handled
);
  logic take;

  always_comb begin
    take = ev && (!blk_valid || (ev_seq < blk_seq));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_valid   <= 1'b0;
      blk_seq     <= '0;
      blk_handled <= 1'b0;
    end else begin
      if (take) begin
        blk_valid   <= 1'b1;
        blk_seq     <= ev_seq;
        blk_handled <= 1'b0;
      end else begin
        if (clr) begin
          blk_valid <= 1'b0;
        end
        if (ack) begin
          blk_handled <= 1'b1;
        end
      end
    end
  end

  // R9
  oldest_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(blk_valid) && blk_valid && !$past(clr)) |-> (blk_seq <= $past(blk_seq)));

  // R10
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(blk_valid) && !blk_valid) |-> $past(clr));
endmodule

// File: rtl/load_issue_ctrl.sv
`timescale 1ns/1ps
module load_issue_ctrl
  import lic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int SEQ_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int NUM_PORTS  = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tick,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [IDX_W-1:0]                req_idx,
  input  logic [SEQ_W-1:0]                req_seq,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [$clog2(LINE_BYTES):0]     req_size,
  input  logic                            req_uncached,
  input  logic                            req_at_commit,
  input  logic                            req_split,
  input  logic [IDX_W-1:0]                head_idx,
  input  logic                            cache_blocked,
  output logic                            mem_valid,
  input  logic                            mem_ready,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic [$clog2(LINE_BYTES):0]     mem_size,
  output logic [$clog2(LINE_BYTES):0]     mem_off,
  output logic                            mem_hi,
  output logic [IDX_W-1:0]                mem_idx,
  input  logic                            rsp_valid,
  input  logic [IDX_W-1:0]                rsp_idx,
  output logic                            resched_valid,
  output logic [IDX_W-1:0]                resched_idx,
  output logic                            retry,
  output logic                            done_valid,
  output logic [IDX_W-1:0]                done_idx,
  input  logic                            blk_clear,
  input  logic                            blk_ack,
  output logic                            blk_valid,
  output logic [SEQ_W-1:0]                blk_seq,
  output logic                            blk_handled,
  output logic [$clog2(NUM_PORTS+3)-1:0]  ports_used
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SZ_W  = OFF_W + 1;
  localparam int PC_W  = $clog2(NUM_PORTS + 3);

  logic             accept;
  lic_class_t       cls;
  logic [PC_W-1:0]  need;
  logic [PC_W-1:0]  port_base;
  logic             idle;
  logic             set_valid;
  logic [IDX_W-1:0] set_idx;
  logic [1:0]       set_cnt;
  logic             lo_fail;
  logic             hi_fail;
  logic [IDX_W-1:0] fail_idx;
  logic             blk_ev;
  logic [SEQ_W-1:0] blk_ev_seq;

  lic_gate #(
    .IDX_W(IDX_W), .NUM_PORTS(NUM_PORTS), .PC_W(PC_W)
  ) u_gate (
    .req_valid(req_valid), .req_idx(req_idx), .head_idx(head_idx),
    .req_uncached(req_uncached), .req_at_commit(req_at_commit),
    .req_split(req_split), .cache_blocked(cache_blocked), .tick(tick),
    .idle(idle), .ports_used(ports_used), .req_ready(req_ready),
    .accept(accept), .cls(cls), .need(need), .port_base(port_base)
  );

  lic_issue #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .LINE_BYTES(LINE_BYTES),
    .NUM_PORTS(NUM_PORTS), .PC_W(PC_W), .OFF_W(OFF_W), .SZ_W(SZ_W)
  ) u_issue (
    .clk(clk), .rst(rst), .accept(accept), .cls(cls), .need(need),
    .port_base(port_base), .req_idx(req_idx), .req_seq(req_seq),
    .req_addr(req_addr), .req_size(req_size), .req_split(req_split),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_off(mem_off), .mem_hi(mem_hi),
    .mem_idx(mem_idx), .resched_valid(resched_valid),
    .resched_idx(resched_idx), .retry(retry), .ports_used(ports_used),
    .idle(idle), .set_valid(set_valid), .set_idx(set_idx),
    .set_cnt(set_cnt), .lo_fail(lo_fail), .hi_fail(hi_fail),
    .fail_idx(fail_idx), .blk_ev(blk_ev), .blk_ev_seq(blk_ev_seq)
  );

  lic_track #(
    .IDX_W(IDX_W)
  ) u_track (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_idx(set_idx),
    .set_cnt(set_cnt), .lo_fail(lo_fail), .hi_fail(hi_fail),
    .fail_idx(fail_idx), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx),
    .done_valid(done_valid), .done_idx(done_idx)
  );

  lic_blocked #(
    .SEQ_W(SEQ_W)
  ) u_blocked (
    .clk(clk), .rst(rst), .ev(blk_ev), .ev_seq(blk_ev_seq),
    .clr(blk_clear), .ack(blk_ack), .blk_valid(blk_valid),
    .blk_seq(blk_seq), .blk_handled(blk_handled)
  );
endmodule

// File: tb/load_issue_ctrl_test.sv
`timescale 1ns/1ps
module load_issue_ctrl_test;
  localparam int NPORT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_idx = '0;
  logic [15:0] req_seq = '0;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_size = '0;
  logic        req_uncached = 1'b0;
  logic        req_at_commit = 1'b0;
  logic        req_split = 1'b0;
  logic [3:0]  head_idx = '0;
  logic        cache_blocked = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [4:0]  mem_size;
  logic [4:0]  mem_off;
  logic        mem_hi;
  logic [3:0]  mem_idx;
  logic        rsp_valid = 1'b0;
  logic [3:0]  rsp_idx = '0;
  logic        resched_valid;
  logic [3:0]  resched_idx;
  logic        retry;
  logic        done_valid;
  logic [3:0]  done_idx;
  logic        blk_clear = 1'b0;
  logic        blk_ack = 1'b0;
  logic        blk_valid;
  logic [15:0] blk_seq;
  logic        blk_handled;
  logic [2:0]  ports_used;

  load_issue_ctrl uut (.*);

  always #5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  // Bench model state
  int e_cnt [16];
  bit e_bv = 1'b0;
  int e_bs = 0;
  bit e_bh = 1'b0;
  int e_ports = 0;

  task automatic chk(input string r, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int lo_size(input int addr, input int size, input bit split);
    return split ? (16 - (addr % 16)) : size;
  endfunction

  function automatic bit gate_ok(input int idx, input int head, input bit unc, input bit atc);
    return !unc || (idx == head && atc);
  endfunction

  task automatic blk_offer(input int seq);
    if (!e_bv || seq < e_bs) begin
      e_bv = 1'b1;
      e_bs = seq;
      e_bh = 1'b0;
    end
  endtask

  task automatic chk_blk(input string r);
    chk({r, " blk_valid"}, blk_valid, e_bv);
    if (e_bv) begin
      chk({r, " blk_seq"}, blk_seq, e_bs);
      chk({r, " blk_handled"}, blk_handled, e_bh);
    end
  endtask

  // Offer one load and follow it to the end of its requests.
  task automatic run_load(input int idx, input int seq, input int addr, input int size,
                          input bit unc, input bit atc, input bit split, input int head,
                          input bit blkd, input bit rdy_lo, input bit rdy_hi, input bit tk);
    int need;
    int base;
    int lo;
    need = split ? 2 : 1;
    @(negedge clk);
    tick = tk; req_valid = 1'b1; req_idx = 4'(idx); req_seq = 16'(seq);
    req_addr = 32'(addr); req_size = 5'(size); req_uncached = unc;
    req_at_commit = atc; req_split = split; head_idx = 4'(head);
    cache_blocked = blkd;
    base = tk ? 0 : e_ports;
    #1;
    chk("R12 ready", req_ready, (base + need) <= NPORT);
    @(negedge clk);
    req_valid = 1'b0; tick = 1'b0; cache_blocked = 1'b0;
    if (!gate_ok(idx, head, unc, atc)) begin
      e_ports = base;
      chk("R1 resched", resched_valid, 1);
      chk("R1 resched_idx", resched_idx, idx);
      chk("R1 no request", mem_valid, 0);
      chk("R1 no port", ports_used, e_ports);
      chk_blk("R1");
    end else if (blkd) begin
      e_ports = base;
      blk_offer(seq);
      chk("R8 no request", mem_valid, 0);
      chk("R8 no port", ports_used, e_ports);
      chk("R8 no resched", resched_valid, 0);
      chk_blk("R8");
    end else begin
      e_ports = base + need;
      e_cnt[idx] = need;
      lo = lo_size(addr, size, split);
      chk("R11 ports", ports_used, e_ports);
      chk("R2/R3 mem_valid", mem_valid, 1);
      chk("R3 mem_hi", mem_hi, 0);
      chk("R3 mem_addr", mem_addr, addr);
      chk("R4 low size", mem_size, lo);
      chk("R3 mem_off", mem_off, 0);
      chk("R3 mem_idx", mem_idx, idx);
      chk("R1 no resched", resched_valid, 0);
      mem_ready = rdy_lo;
      @(negedge clk);
      mem_ready = 1'b0;
      if (!rdy_lo) begin
        e_cnt[idx] = 0;
        blk_offer(seq);
        chk("R7 retry", retry, 1);
        chk("R7 idle", mem_valid, 0);
        chk_blk("R7");
      end else if (split) begin
        chk("R4 high valid", mem_valid, 1);
        chk("R4 high flag", mem_hi, 1);
        chk("R4 high addr", mem_addr, (addr & ~15) + 16);
        chk("R4 high size", mem_size, size - lo);
        chk("R4 high off", mem_off, lo);
        chk("R4 no retry", retry, 0);
        mem_ready = rdy_hi;
        @(negedge clk);
        mem_ready = 1'b0;
        if (!rdy_hi) begin
          e_cnt[idx] = e_cnt[idx] - 1;
          blk_offer(seq);
          chk("R6 retry", retry, 1);
          chk_blk("R6");
        end else begin
          chk("R4 no retry", retry, 0);
        end
        chk("R4 done", mem_valid, 0);
      end else begin
        chk("R3 single", mem_valid, 0);
        chk("R3 no retry", retry, 0);
      end
    end
  endtask

  task automatic send_rsp(input int idx);
    bit exp_done;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_idx = 4'(idx);
    @(negedge clk);
    rsp_valid = 1'b0;
    exp_done = 1'b0;
    if (e_cnt[idx] > 0) begin
      e_cnt[idx] = e_cnt[idx] - 1;
      exp_done = (e_cnt[idx] == 0);
    end
    chk("R5 done", done_valid, exp_done);
    if (exp_done) chk("R5 done_idx", done_idx, idx);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    blk_clear = 1'b1;
    @(negedge clk);
    blk_clear = 1'b0;
    e_bv = 1'b0;
    chk("R10 cleared", blk_valid, 0);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    blk_ack = 1'b1;
    @(negedge clk);
    blk_ack = 1'b0;
    if (e_bv) e_bh = 1'b1;
    chk_blk("R9 ack");
  endtask

  task automatic probe(input bit split, input bit exp);
    @(negedge clk);
    req_valid = 1'b0; tick = 1'b0; req_split = split;
    #1;
    chk("R12 probe", req_ready, exp);
  endtask

  initial begin
    #(10 * 150000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51d3));
    for (int i = 0; i < 16; i++) e_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R3 reset mem_valid", mem_valid, 0);
    chk("R10 reset blk_valid", blk_valid, 0);
    chk("R11 reset ports", ports_used, 0);
    chk("R5 reset done", done_valid, 0);

    // R3 / R5: unsplit load, extra response ignored
    run_load(3, 100, 32'h2004, 4, 0, 0, 0, 0, 0, 1, 1, 1);
    send_rsp(3);
    send_rsp(3);
    // R4 / R5: split load, completes on second response
    run_load(5, 101, 32'h100C, 8, 0, 0, 1, 0, 0, 1, 1, 1);
    send_rsp(5);
    send_rsp(5);
    // R1: uncacheable away from head, then at head but not committing
    run_load(6, 102, 32'h3000, 8, 1, 1, 0, 2, 0, 1, 1, 1);
    run_load(6, 103, 32'h3000, 8, 1, 0, 0, 6, 0, 1, 1, 1);
    send_rsp(6);
    // R2: uncacheable at head and commit issues
    run_load(7, 104, 32'h3008, 8, 1, 1, 0, 7, 0, 1, 1, 1);
    send_rsp(7);
    // R6: high part refused, one response completes
    run_load(8, 500, 32'h400E, 4, 0, 0, 1, 0, 0, 1, 0, 1);
    send_rsp(8);
    // R7: low part refused, response ignored
    run_load(9, 400, 32'h4100, 2, 0, 0, 0, 0, 0, 0, 1, 1);
    send_rsp(9);
    // R8 / R9: blocked loads, only older one replaces
    run_load(10, 450, 32'h5000, 1, 0, 0, 0, 0, 1, 1, 1, 1);
    pulse_ack();
    run_load(11, 300, 32'h5001, 1, 0, 0, 0, 0, 1, 1, 1, 1);
    run_load(12, 300, 32'h5002, 1, 0, 0, 0, 0, 1, 1, 1, 1);
    pulse_ack();
    repeat (4) @(negedge clk);
    chk_blk("R10 hold");
    pulse_clear();
    // R11 / R12: port budget across loads without tick
    run_load(1, 600, 32'h6000, 4, 0, 0, 0, 0, 0, 1, 1, 1);
    probe(1, 0);
    probe(0, 1);
    run_load(2, 601, 32'h6004, 4, 0, 0, 0, 0, 0, 1, 1, 0);
    probe(0, 0);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    e_ports = 0;
    chk("R11 tick reset", ports_used, 0);
    probe(1, 1);
    send_rsp(1);
    send_rsp(2);

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      int idx, head, addr, size, off;
      bit unc, atc, split, blkd, rl, rh;
      idx = int'($urandom % 16);
      head = ($urandom % 2 == 0) ? idx : int'($urandom % 16);
      unc = ($urandom % 4 == 0);
      atc = $urandom % 2;
      split = ($urandom % 3 == 0);
      blkd = ($urandom % 6 == 0);
      rl = ($urandom % 5 != 0);
      rh = ($urandom % 5 != 0);
      if (split) begin
        off = 9 + int'($urandom % 7);
        size = 8;
      end else begin
        size = 1 << ($urandom % 4);
        off = int'($urandom % (16 / size)) * size;
      end
      addr = (int'($urandom % 4096) << 4) + off;
      run_load(idx, int'($urandom % 65536), addr, size, unc, atc, split, head,
               blkd, rl, rh, 1);
      if ($urandom % 2 == 0) send_rsp(int'($urandom % 16));
      if ($urandom % 3 == 0) send_rsp(idx);
      if (it % 40 == 39) pulse_clear();
      if (it % 25 == 24) pulse_ack();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule